// File: doc/BRIEF.md
# Multiplexed-Bus External Read Sequencer

This block runs read transactions on an external bus where one 16-bit set of wires carries the address first and the returned data afterwards. Each clock is one phase tick; four ticks, named Q1 to Q4, make one instruction cycle. A read takes exactly one instruction cycle, and a new request can follow the previous one without any gap.

In a read, the block puts the address on the bus and raises ALE for Q1. In Q2 it lowers ALE and keeps the address on the bus, so the external latch has hold time. In Q3 and Q4 it releases the bus and holds the active-low output enable low. On the edge that ends Q4 it raises the output enable, captures the word on the bus input, and starts driving the next address. The captured word comes out with a one-tick valid pulse in the following Q1. The write strobe stays high throughout.

The internal side presents a request and an address. Requests are sampled only at the boundary into Q1.

Top module: `mux_rd_seq`

States: IDLE (bus released, waiting), ADDR (Q1: address out, ALE high), HOLD (Q2: ALE low, address held), REL (Q3: bus released, OE low), READ (Q4: bus released, OE low). Transitions: IDLE→ADDR when a request is seen on the edge that ends Q4; ADDR→HOLD, HOLD→REL and REL→READ always; READ→ADDR when a request is present, otherwise READ→IDLE.

## Requirements
- R1: While and right after synchronous reset: ale=0, oe_n=1, wr_n=1, bus_oe=0, rd_valid=0 and q_phase=0.
- R2: q_phase advances by one every clock through 0,1,2,3 (Q1..Q4) and wraps from 3 to 0.
- R3: rd_req and rd_addr are sampled only on the clock edge that ends a tick with q_phase=3. A request raised and dropped at any other time starts no read (ale stays 0 and bus_oe stays 0).
- R4: In Q1 of a read, ale=1, bus_oe=1 and bus_out equals the accepted address. ALE is high for exactly one tick.
- R5: In Q2 of a read, ale=0, bus_oe=1 and bus_out still holds the accepted address.
- R6: In Q3 and Q4 of a read, bus_oe=0 and oe_n=0. oe_n is never 0 in a tick where bus_oe is 1.
- R7: The read word is taken from bus_in on the edge that ends Q4. The value on bus_in during Q3 has no effect on it.
- R8: In the Q1 after a read, rd_valid=1 for exactly one tick and rd_data equals the captured word. rd_data keeps that value afterwards until the next capture.
- R9: A request present at the end of Q4 of an active read starts the next read at once, so consecutive ALE rising edges are four ticks apart.
- R10: wr_n is 1 in every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-tick clock, one edge per quarter instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, sampled at the boundary into Q1 |
| rd_addr | input | 16 | Address for the requested read |
| bus_out | output | 16 | Value driven onto the shared address/data bus |
| bus_oe | output | 1 | 1 when bus_out is driven onto the bus, 0 when the bus is released |
| bus_in | input | 16 | Value sampled from the shared bus |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Output enable to the external memory, active low |
| wr_n | output | 1 | Write strobe, held inactive high |
| rd_data | output | 16 | Last captured read word |
| rd_valid | output | 1 | One-tick pulse marking a new rd_data |
| q_phase | output | 2 | Current phase, 0..3 for Q1..Q4 |

## Verification
A request presented in a Q4 tick changes the outputs in the next tick: ale, bus_oe and bus_out in Q1, ALE low with the address still held one tick later, and the released bus with oe_n low in the third and fourth ticks. The read word appears with rd_valid in the fifth tick. The bench drives inputs on falling edges and checks every tick against the phase it expects. This covers a sweep of addresses under chained reads, idle gaps, and stray requests that are dropped before the sampling edge. The bus_in value during Q3 is made different from the value during Q4, so a capture one tick early would show up as a wrong rd_data.

// File: rtl/rd_seq_pkg.sv
package rd_seq_pkg;

    localparam int NUM_PHASES = 4;
    localparam int PHASE_W    = $clog2(NUM_PHASES);

    localparam logic [PHASE_W-1:0] PH_Q1 = PHASE_W'(0);
    localparam logic [PHASE_W-1:0] PH_Q4 = PHASE_W'(NUM_PHASES - 1);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_HOLD = 3'd2,
        ST_REL  = 3'd3,
        ST_READ = 3'd4
    } seq_state_t;

endpackage

// File: rtl/rd_phase_gen.sv
module rd_phase_gen
    import rd_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [PHASE_W-1:0] phase,
    output logic               last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_Q1;
        end else if (phase == PH_Q4) begin
            phase <= PH_Q1;
        end else begin
            phase <= phase + PHASE_W'(1);
        end
    end

    assign last = (phase == PH_Q4);

endmodule

// File: rtl/rd_seq_fsm.sv
module rd_seq_fsm
    import rd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic last,
    output logic accept,
    output logic capture,
    output logic ale,
    output logic drive,
    output logic oe_n
);

    seq_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (last && req) state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_HOLD;
            ST_HOLD: state_nx = ST_REL;
            ST_REL:  state_nx = ST_READ;
            ST_READ: state_nx = req ? ST_ADDR : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        ale     = 1'b0;
        drive   = 1'b0;
        oe_n    = 1'b1;
        unique case (state)
            ST_IDLE: accept = last && req;
            ST_ADDR: begin
                ale   = 1'b1;
                drive = 1'b1;
            end
            ST_HOLD: drive = 1'b1;
            ST_REL:  oe_n = 1'b0;
            ST_READ: begin
                oe_n    = 1'b0;
                capture = 1'b1;
                accept  = req;
            end
            default: ;
        endcase
    end

    // R6: the read phase always covers exactly two ticks
    a_r6_oe_two_ticks: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |=> !oe_n);

    // R9: a capture is always the last tick of a read
    a_r9_capture_ends_read: assert property (@(posedge clk) disable iff (rst)
        capture |=> oe_n);

endmodule

// File: rtl/rd_data_path.sv
module rd_data_path #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             capture,
    input  logic [BUS_W-1:0] addr_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] data_q,
    output logic             valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture;
            if (capture) begin
                data_q <= bus_in;
            end
        end
    end

    // R8: a valid pulse lasts one tick
    a_r8_valid_one_tick: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R8: data changes only together with a valid pulse
    a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(data_q) || $past(rst));

endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
    import rd_seq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [BUS_W-1:0] rd_addr,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             ale,
    output logic             oe_n,
    output logic             wr_n,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid,
    output logic [1:0]       q_phase
);

    logic [PHASE_W-1:0] phase;
    logic               last;
    logic               accept;
    logic               capture;

    rd_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (last)
    );

    rd_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .last    (last),
        .accept  (accept),
        .capture (capture),
        .ale     (ale),
        .drive   (bus_oe),
        .oe_n    (oe_n)
    );

    rd_data_path #(.BUS_W(BUS_W)) u_path (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .capture (capture),
        .addr_in (rd_addr),
        .bus_in  (bus_in),
        .addr_q  (bus_out),
        .data_q  (rd_data),
        .valid_q (rd_valid)
    );

    assign wr_n    = 1'b1;
    assign q_phase = 2'(phase);

    // R6: never drive the bus while the memory may be driving it
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(bus_oe && !oe_n));

    // R4: ALE only in Q1 and only with the address driven
    a_r4_ale_in_q1: assert property (@(posedge clk) disable iff (rst)
        ale |-> (phase == PH_Q1) && bus_oe);

    // R4: ALE high for one tick
    a_r4_ale_one_tick: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R5: address held and driven after ALE falls
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> bus_oe && $stable(bus_out));

    // R7: a valid pulse follows a tick with OE low
    a_r7_valid_after_oe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!oe_n) && oe_n);

    // R10: write strobe inactive
    a_r10_wr_high: assert property (@(posedge clk) disable iff (rst)
        wr_n);

endmodule

// File: tb/mux_rd_seq_test.sv
module mux_rd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] bus_in = 16'hDEAD;
    logic [15:0] bus_out;
    logic        bus_oe, ale, oe_n, wr_n, rd_valid;
    logic [15:0] rd_data;
    logic [1:0]  q_phase;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    bit          pend   = 1'b0;
    logic [15:0] last_d = '0;

    always #10 clk = ~clk;

    mux_rd_seq uut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .ale(ale), .oe_n(oe_n), .wr_n(wr_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .q_phase(q_phase)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // checks common to every tick
    task automatic tick_common(input logic [1:0] ph);
        chk("R2 phase", 16'(q_phase), 16'(ph));
        chk("R10 wr_n", 16'(wr_n), 16'd1);
        chk("R6 no drive with oe low", 16'(bus_oe & ~oe_n), 16'd0);
    endtask

    task automatic valid_check();
        if (pend) begin
            chk("R8 valid pulse", 16'(rd_valid), 16'd1);
            chk("R8 data", rd_data, last_d);
            pend = 1'b0;
        end else begin
            chk("R8 no valid", 16'(rd_valid), 16'd0);
        end
    endtask

    // entered at the falling edge of a Q4 tick, leaves at the next Q4 falling edge
    task automatic do_read(input logic [15:0] a, input bit stray);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        tick_common(2'd0);
        valid_check();
        chk("R4 ale Q1", 16'(ale), 16'd1);
        chk("R4 drive Q1", 16'(bus_oe), 16'd1);
        chk("R4 addr Q1", bus_out, a);
        chk("R9 oe high Q1", 16'(oe_n), 16'd1);
        rd_req = 1'b0; rd_addr = ~a;
        @(negedge clk);
        tick_common(2'd1);
        chk("R8 no valid Q2", 16'(rd_valid), 16'd0);
        chk("R8 data held", rd_data, last_d);
        chk("R5 ale low Q2", 16'(ale), 16'd0);
        chk("R5 drive Q2", 16'(bus_oe), 16'd1);
        chk("R5 addr held Q2", bus_out, a);
        if (stray) begin rd_req = 1'b1; rd_addr = a ^ 16'hFFFF; end
        @(negedge clk);
        tick_common(2'd2);
        chk("R6 released Q3", 16'(bus_oe), 16'd0);
        chk("R6 oe low Q3", 16'(oe_n), 16'd0);
        rd_req = 1'b0;
        bus_in = ~mem_word(a);
        @(negedge clk);
        tick_common(2'd3);
        chk("R6 released Q4", 16'(bus_oe), 16'd0);
        chk("R6 oe low Q4", 16'(oe_n), 16'd0);
        bus_in = mem_word(a);
        pend = 1'b1;
        last_d = mem_word(a);
    endtask

    // one idle instruction cycle; mode 1 raises a stray request in Q1..Q2
    task automatic idle_cycle(input int mode, input logic [15:0] a);
        rd_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bus_in = 16'hDEAD;
            tick_common(2'(k));
            if (k == 0) valid_check();
            else chk("R8 data held idle", rd_data, last_d);
            chk("R3 no ale idle", 16'(ale), 16'd0);
            chk("R3 no drive idle", 16'(bus_oe), 16'd0);
            chk("R6 oe high idle", 16'(oe_n), 16'd1);
            if (mode == 1 && k == 0) begin rd_req = 1'b1; rd_addr = a; end
            if (k == 2) rd_req = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ale", 16'(ale), 16'd0);
        chk("R1 oe_n", 16'(oe_n), 16'd1);
        chk("R1 wr_n", 16'(wr_n), 16'd1);
        chk("R1 bus_oe", 16'(bus_oe), 16'd0);
        chk("R1 valid", 16'(rd_valid), 16'd0);
        chk("R1 phase", 16'(q_phase), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 phase after reset", 16'(q_phase), 16'd1);
        chk("R1 ale after reset", 16'(ale), 16'd0);
        while (q_phase != 2'd3) @(negedge clk);
        for (int i = 0; i < 96; i++) begin
            logic [15:0] a;
            a = 16'(i * 16'h0A51) ^ 16'(i << 11) ^ 16'h1234;
            if (i == 5) a = 16'h0000;
            if (i == 6) a = 16'hFFFF;
            do_read(a, i[0]);
            case (i % 4)
                0: ;                       // R9 chained reads
                1: idle_cycle(0, a);
                2: idle_cycle(1, ~a);      // R3 stray request ignored
                default: begin idle_cycle(0, a); idle_cycle(1, a ^ 16'h00FF); end
            endcase
        end
        idle_cycle(0, 16'h0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule